// File: doc/BRIEF.md
# Latched Analog-Switch Channel Controller

This block is the digital control for an eight-way analog switch array. A host places a channel address and an enable bit on the inputs and works two active-low strobes. The write strobe makes the selection register transparent while low and freezes it while high. The reset strobe, once held low long enough, clears the selection to all-off. The decoded selection drives one switch-on line per analog switch. Every change of selection passes through a sequencer that first turns every line off for a fixed gap. Two lines of different selections are therefore never on in adjacent cycles.

A mode pin turns the same logic into a four-pair differential selector. Here the two low address bits pick a pair, and both halves of that pair close together. All strobe, address, enable and mode pins are sampled through a two-flop synchronizer on the block clock. Apart from its reset, the block has no other inputs.

Top module: `latch_mux_ctrl`

## Requirements
- R1: After the system reset `rst_n` is released, all `sw_o` lines are 0 and `settling_o` is 0.
- R2: While `wr_n_i` is low and `rs_n_i` is high, the selection follows `addr_i` and `en_i`. A change at the pins holds the old `sw_o` for 3 clock edges, turns all lines off with `settling_o` high after the 4th edge, and shows the new selection after edge 4+`GAP_CYC`.
- R3: On a rising edge of `wr_n_i`, the address and enable values present on that edge are stored. While `wr_n_i` stays high, changes of `addr_i` and `en_i` have no effect on `sw_o`.
- R4: With `diff_i`=0 and the stored enable at 1, address value k turns on only `sw_o[k]`, so address 0 selects the first line and 7 the last.
- R5: With `diff_i`=1 and the stored enable at 1, only `addr_i[1:0]` matters. Value k turns on `sw_o[k]` (the A switch of pair k) and `sw_o[k+4]` (its B switch). `addr_i[2]` has no effect.
- R6: With the stored enable at 0, every `sw_o` line is 0 in both modes.
- R7: `rs_n_i` held low for at least `RST_MIN` clock cycles clears the stored address and enable, so every line goes off. This overrides `wr_n_i` being low. The cleared state remains after `rs_n_i` returns high while `wr_n_i` is high.
- R8: A low pulse on `rs_n_i` shorter than `RST_MIN` cycles leaves the stored selection and `sw_o` unchanged.
- R9: Each change of decoded selection forces all `sw_o` lines to 0 for `GAP_CYC` cycles with `settling_o` high. `sw_o` never moves from one nonzero pattern to a different nonzero pattern in one cycle.
- R10: A new selection arriving during a gap restarts the gap. Only the latest selection is then applied, and the superseded one never appears on `sw_o`.
- R11: An input change that leaves the decoded selection the same inserts no gap. `settling_o` stays 0 and `sw_o` is unchanged.
- R12: `sw_o` never has more than one line on in single-ended use, or more than one A/B pair (bits k and k+4) in differential use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| addr_i | input | 3 | Channel address (pair address in bits 1:0 in differential mode) |
| en_i | input | 1 | Enable bit; 0 turns every switch off |
| wr_n_i | input | 1 | Write strobe, active low: transparent while low, holds while high |
| rs_n_i | input | 1 | Reset strobe, active low, with minimum width `RST_MIN` |
| diff_i | input | 1 | 0 = single-ended one-of-eight, 1 = differential one-of-four pairs |
| sw_o | output | 8 | Switch-on lines, one per analog switch |
| settling_o | output | 1 | High during every break-before-make gap |

## Verification
A wrong stored address or enable shows up on `sw_o` as the wrong line pattern. It appears `GAP_CYC` cycles after the selection pipeline delivers it, so the mapping sweep catches it one gap after every step. A broken gap counter or restart path shows up as a lit line while `settling_o` is high, or as a gap of the wrong length at the exact edge the bench samples. A faulty reset-width counter shows up as a selection that survives a full-width reset pulse, or one lost to a pulse one cycle too short, seen a few cycles after the strobe returns high.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_PAIR   = 1'b1
  } lmc_mode_e;

  localparam int unsigned LMC_ADDR_W_DEF  = 3;
  localparam int unsigned LMC_SYNC_DEF    = 2;
  localparam int unsigned LMC_GAP_DEF     = 2;
  localparam int unsigned LMC_RST_MIN_DEF = 4;
endpackage

// File: rtl/lmc_sync.sv
module lmc_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= RST_VAL;
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lmc_latch_reg.sv
module lmc_latch_reg #(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned RST_MIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic              en_s,
  input  logic              wr_n_s,
  input  logic              rs_n_s,
  output logic [ADDR_W-1:0] addr_q,
  output logic              en_q
);
  localparam int unsigned CW = $clog2(RST_MIN + 1);
  localparam logic [CW-1:0] LIM      = CW'(RST_MIN);
  localparam logic [CW-1:0] LIM_LAST = CW'(RST_MIN - 1);

  logic [CW-1:0] low_cnt;
  logic          clear_hit;

  // consecutive low cycles of the synchronized reset strobe, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (rs_n_s) begin
      low_cnt <= '0;
    end else if (low_cnt != LIM) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign clear_hit = !rs_n_s && (low_cnt >= LIM_LAST);

  // clear beats hold beats follow
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      en_q   <= 1'b0;
    end else if (clear_hit) begin
      addr_q <= '0;
      en_q   <= 1'b0;
    end else if (rs_n_s && !wr_n_s) begin
      addr_q <= addr_s;
      en_q   <= en_s;
    end
  end
endmodule

// File: rtl/lmc_decode.sv
module lmc_decode #(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned CH    = 1 << ADDR_W,
  localparam int unsigned HALF  = CH / 2
) (
  input  logic              [ADDR_W-1:0] addr_i,
  input  logic                           en_i,
  input  lmc_pkg::lmc_mode_e             mode_i,
  output logic              [CH-1:0]     sel_o
);
  for (genvar k = 0; k < CH; k++) begin : g_line
    localparam int unsigned PAIR = k % HALF;
    logic hit_single;
    logic hit_pair;
    assign hit_single = (addr_i == ADDR_W'(k));
    assign hit_pair   = (addr_i[ADDR_W-2:0] == (ADDR_W-1)'(PAIR));
    assign sel_o[k]   = en_i &&
                        ((mode_i == lmc_pkg::MODE_PAIR) ? hit_pair : hit_single);
  end
endmodule

// File: rtl/lmc_bbm.sv
module lmc_bbm #(
  parameter int unsigned CH      = 8,
  parameter int unsigned GAP_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] target_i,
  output logic [CH-1:0] sw_o,
  output logic          settling_o
);
  localparam int unsigned GW = $clog2(GAP_CYC + 1);
  localparam logic [GW-1:0] GAP_LD = GW'(GAP_CYC);

  logic [CH-1:0] want_q;
  logic [CH-1:0] out_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q <= '0;
      out_q  <= '0;
      gap_q  <= '0;
    end else if (target_i != want_q) begin
      want_q <= target_i;
      out_q  <= '0;
      gap_q  <= GAP_LD;
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
      if (gap_q == GW'(1)) begin
        out_q <= want_q;
      end
    end
  end

  assign sw_o       = out_q;
  assign settling_o = (gap_q != '0);
endmodule

// File: rtl/latch_mux_ctrl.sv
module latch_mux_ctrl #(
  parameter int unsigned ADDR_W   = lmc_pkg::LMC_ADDR_W_DEF,
  parameter int unsigned SYNC_STG = lmc_pkg::LMC_SYNC_DEF,
  parameter int unsigned GAP_CYC  = lmc_pkg::LMC_GAP_DEF,
  parameter int unsigned RST_MIN  = lmc_pkg::LMC_RST_MIN_DEF,
  localparam int unsigned CH      = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  input  logic              wr_n_i,
  input  logic              rs_n_i,
  input  logic              diff_i,
  output logic [CH-1:0]     sw_o,
  output logic              settling_o
);
  localparam int unsigned PW = ADDR_W + 4;
  // packing: {diff, en, addr, rs_n, wr_n}; strobes idle high
  localparam logic [PW-1:0] PIN_IDLE = PW'(3);

  logic [PW-1:0]     pins_raw;
  logic [PW-1:0]     pins_s;
  logic [ADDR_W-1:0] addr_q;
  logic              en_q;
  logic [CH-1:0]     target;
  lmc_pkg::lmc_mode_e mode_s;

  assign pins_raw = {diff_i, en_i, addr_i, rs_n_i, wr_n_i};

  lmc_sync #(.WIDTH(PW), .STAGES(SYNC_STG), .RST_VAL(PIN_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign mode_s = lmc_pkg::lmc_mode_e'(pins_s[PW-1]);

  lmc_latch_reg #(.ADDR_W(ADDR_W), .RST_MIN(RST_MIN)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr_s (pins_s[ADDR_W+1:2]),
    .en_s   (pins_s[ADDR_W+2]),
    .wr_n_s (pins_s[0]),
    .rs_n_s (pins_s[1]),
    .addr_q (addr_q),
    .en_q   (en_q)
  );

  lmc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_q),
    .en_i   (en_q),
    .mode_i (mode_s),
    .sel_o  (target)
  );

  lmc_bbm #(.CH(CH), .GAP_CYC(GAP_CYC)) u_bbm (
    .clk        (clk),
    .rst_n      (rst_n),
    .target_i   (target),
    .sw_o       (sw_o),
    .settling_o (settling_o)
  );
endmodule

// File: rtl/lmc_checker.sv
module lmc_checker #(
  parameter int unsigned CH = 8,
  localparam int unsigned HALF = CH / 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CH-1:0] sw_o,
  input logic          settling_o
);
  // R12: at most one line, or exactly one matching A/B pair
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sw_o) <= 2) &&
    (($countones(sw_o) == 2) -> (sw_o[HALF-1:0] == sw_o[CH-1:HALF])));

  // R9: nothing lit while a gap is running
  a_r9_gap_dark: assert property (@(posedge clk) disable iff (!rst_n)
    settling_o |-> (sw_o == '0));

  // R9: no direct swap between two different lit patterns
  a_r9_no_direct_swap: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_o != '0) && ($past(sw_o) != '0)) |-> (sw_o == $past(sw_o)));

  // R9: a newly lit pattern is always preceded by a gap cycle
  a_r9_gap_before_on: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_o != '0) && (sw_o != $past(sw_o))) |-> $past(settling_o));
endmodule

bind latch_mux_ctrl lmc_checker #(.CH(CH)) u_lmc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_o       (sw_o),
  .settling_o (settling_o)
);

// File: tb/tb_latch_mux_ctrl.sv
module tb_latch_mux_ctrl;
  localparam int GAP  = 2;
  localparam int RMIN = 4;
  localparam int LAT  = 4;   // edges from pin change to gap start

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       en = 1'b0;
  logic       wr_n = 1'b0;
  logic       rs_n = 1'b1;
  logic       diff = 1'b0;
  logic [7:0] sw;
  logic       settling;

  int n_chk = 0;
  int n_fail = 0;
  int mon_err = 0;
  bit watch_on = 1'b0;
  logic [7:0] watch_val = '0;
  bit watch_seen = 1'b0;
  bit settle_seen = 1'b0;

  always #5 clk = ~clk;

  latch_mux_ctrl #(.ADDR_W(3), .SYNC_STG(2), .GAP_CYC(GAP), .RST_MIN(RMIN)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .en_i(en), .wr_n_i(wr_n),
    .rs_n_i(rs_n), .diff_i(diff), .sw_o(sw), .settling_o(settling)
  );

  function automatic logic [7:0] expect_sel(input logic [2:0] a, input logic e, input logic d);
    if (!e) return 8'h00;
    if (d) return (8'h01 << a[1:0]) | (8'h10 << a[1:0]);
    return 8'h01 << a;
  endfunction

  // R12 / R9 port monitor
  logic [7:0] prev_sw = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones(sw) > 2) mon_err++;
      if ($countones(sw) == 2 && sw[3:0] != sw[7:4]) mon_err++;
      if (sw != 0 && prev_sw != 0 && sw != prev_sw) mon_err++;
      if (watch_on && sw == watch_val) watch_seen = 1'b1;
      if (watch_on && settling) settle_seen = 1'b1;
    end
    prev_sw = sw;
  end

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] old_v;
    logic [7:0] new_v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(1);
    // R1
    check(sw == 0 && settling == 0, "R1 reset state", sw, 8'h00);

    // R2 R4 R5 R6: transparent sweep over both modes, enable and address
    for (int d = 0; d < 2; d++) begin
      for (int e = 0; e < 2; e++) begin
        for (int a = 0; a < 8; a++) begin
          diff = d[0]; en = e[0]; addr = a[2:0];
          tick(LAT + GAP + 1);
          new_v = expect_sel(addr, en, diff);
          if (e == 0)
            check(sw == new_v && !settling, "R6 enable low all off", sw, new_v);
          else if (d == 0)
            check(sw == new_v && !settling, "R4 single-ended map", sw, new_v);
          else
            check(sw == new_v && !settling, "R5 pair map", sw, new_v);
        end
      end
    end

    // R2 latency and R9 gap shape
    diff = 0; en = 1; addr = 3'd2;
    tick(LAT + GAP + 1);
    old_v = 8'h04;
    addr = 3'd5;
    new_v = 8'h20;
    tick(LAT - 1);
    check(sw == old_v && !settling, "R2 old value held through pipeline", sw, old_v);
    tick(1);
    check(sw == 0 && settling, "R9 gap starts dark", sw, 8'h00);
    tick(GAP - 1);
    check(sw == 0 && settling, "R9 gap lasts GAP cycles", sw, 8'h00);
    tick(1);
    check(sw == new_v && !settling, "R2 new selection after gap", sw, new_v);

    // R10: change again inside the gap
    watch_val = 8'h02; watch_seen = 0; watch_on = 1;
    addr = 3'd1;
    tick(1);
    addr = 3'd6;
    tick(LAT + GAP - 1);
    check(sw == 0 && settling, "R10 gap restarted", sw, 8'h00);
    tick(1);
    check(sw == 8'h40 && !settling, "R10 latest applied", sw, 8'h40);
    watch_on = 0;
    check(!watch_seen, "R10 superseded never shown", 8'(watch_seen), 8'h00);

    // R11: same pair in differential mode, addr[2] flips only
    diff = 1; addr = 3'd6;
    tick(LAT + GAP + 1);
    new_v = 8'h44;
    check(sw == new_v, "R5 pair 2", sw, new_v);
    settle_seen = 0; watch_val = 8'hFF; watch_on = 1;
    addr = 3'd2;
    tick(LAT + GAP + 2);
    watch_on = 0;
    check(sw == new_v && !settle_seen, "R11 no gap on same selection", sw, new_v);

    // R3: capture on write rise, ignore inputs while high
    diff = 0; addr = 3'd3; en = 1;
    tick(LAT + GAP + 1);
    wr_n = 1;
    tick(1);
    addr = 3'd7; en = 0;
    tick(LAT + GAP + 4);
    check(sw == 8'h08 && !settling, "R3 held while write high", sw, 8'h08);
    en = 1;
    wr_n = 0;
    tick(LAT + GAP + 1);
    check(sw == 8'h80, "R3 transparent again", sw, 8'h80);
    wr_n = 1;
    tick(2);
    addr = 3'd0;

    // R8: reset pulse one cycle too short
    rs_n = 0;
    tick(RMIN - 1);
    rs_n = 1;
    tick(LAT + GAP + 4);
    check(sw == 8'h80 && !settling, "R8 short reset ignored", sw, 8'h80);

    // R7: reset of exactly the minimum width
    rs_n = 0;
    tick(RMIN);
    rs_n = 1;
    tick(LAT + GAP + 2);
    check(sw == 0, "R7 minimum reset clears", sw, 8'h00);
    tick(8);
    check(sw == 0 && !settling, "R7 cleared state held", sw, 8'h00);

    // R7: reset overrides transparent write
    addr = 3'd4; en = 1;
    rs_n = 0;
    wr_n = 0;
    tick(RMIN + LAT + GAP + 4);
    check(sw == 0, "R7 reset overrides write", sw, 8'h00);
    rs_n = 1;
    tick(LAT + GAP + 1);
    check(sw == 8'h10, "R2 follows after reset release", sw, 8'h10);

    // R12 / R9 monitor totals
    check(mon_err == 0, "R12 R9 exclusion and break-before-make", 8'(mon_err), 8'h00);
    finish_run();
  end
endmodule